// File: doc/BRIEF.md
# List Register Access Permission Decoder

This block decides, in a single combinational pass, what happens to a system-register read or write that targets the interrupt list registers. It takes the five instruction encoding fields (op0, op1, CRn, CRm, op2), the current exception level, three nested-virtualization control bits, the register-enable bits for EL2 and EL3, and four feature-presence inputs. It returns one outcome:

- undefined;
- trap to EL2;
- trap to EL3;
- redirect to memory at a computed offset;
- direct access to the list register entry with a decoded index.

The read/write direction passes through unchanged. The same rules apply to reads and writes.

The block sits beside the system-register decode stage. An encoding that does not address the list registers raises a separate no-match flag and leaves every outcome flag low. In that case another decoder owns the instruction. Register storage, the memory access itself and exception entry are handled elsewhere.

Top module: `lrAccessCheck`

## Requirements
- R1: The encoding matches only when op0=2'b11, op1=3'b100, CRn=4'b1100 and CRm[3:1]=3'b110. Otherwise `noMatch` is 1 and all five outcome flags, `entryIdx`, `memAddr` and `trapClass` are 0.
- R2: On a match, exactly one of `isUndef`, `trapToEl2`, `trapToEl3`, `toMem`, `direct` is 1, and `noMatch` is 0.
- R3: If `hasIrqCtl` is 0, or both `hasEl2` and `hasEl3` are 0, or `has64` is 0, a matched access is undefined. This rule wins over every other rule.
- R4: The entry index is {CRm[0], op2[2:0]}. When it is at or above NUM_LR (default 4), a matched access is undefined. This rule comes second in priority.
- R5: A matched access at EL0 (`curEl`=2'd0) is undefined.
- R6: At EL1 (`curEl`=2'd1), when `nvCtl[2]` and `nvCtl[0]` are both 1, the access redirects to memory at `memAddr` = MEM_BASE (default 12'h400) + 8 × index.
- R7: At EL1, when `nvCtl[0]` is 1 and `nvCtl[2]` is 0, the access traps to EL2. When `nvCtl[0]` is 0, the access is undefined.
- R8: At EL2 (`curEl`=2'd2), the access traps to EL2 when `sreEl2` is 0. Otherwise it is a direct access.
- R9: At EL3 (`curEl`=2'd3), the access traps to EL3 when `sreEl3` is 0. Otherwise it is a direct access.
- R10: `entryIdx` carries the index only while `direct` or `toMem` is 1 and is 0 otherwise. `memAddr` is 0 unless `toMem` is 1. `trapClass` is 6'h18 while either trap flag is 1 and 0 otherwise.
- R11: `isWriteOut` always equals `isWrite`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op0 | input | 2 | Encoding field op0 |
| op1 | input | 3 | Encoding field op1 |
| crn | input | 4 | Encoding field CRn |
| crm | input | 4 | Encoding field CRm |
| op2 | input | 3 | Encoding field op2 |
| curEl | input | 2 | Current exception level, 0 to 3 |
| nvCtl | input | 3 | Nested-virtualization bits; bit 2 and bit 0 are decoded |
| sreEl2 | input | 1 | System-register interface enable for EL2 |
| sreEl3 | input | 1 | System-register interface enable for EL3 |
| hasIrqCtl | input | 1 | Interrupt controller feature present |
| hasEl2 | input | 1 | EL2 implemented |
| hasEl3 | input | 1 | EL3 implemented |
| has64 | input | 1 | 64-bit execution supported |
| isWrite | input | 1 | 1 for a write, 0 for a read |
| noMatch | output | 1 | Encoding is not a list register access |
| isUndef | output | 1 | Access is undefined |
| trapToEl2 | output | 1 | Access traps to EL2 |
| trapToEl3 | output | 1 | Access traps to EL3 |
| toMem | output | 1 | Access redirects to memory |
| direct | output | 1 | Access reaches the list register directly |
| entryIdx | output | 4 | Decoded entry index, valid with direct or toMem |
| memAddr | output | 12 | Redirect offset, valid with toMem |
| trapClass | output | 6 | Syndrome class, valid with a trap flag |
| isWriteOut | output | 1 | Direction, passed through |

## Verification
Every output is a pure function of the current inputs, with no register between them, so each result is due in the same cycle the stimulus is applied. The bench changes inputs just after a rising clock edge and samples at the following falling edge. It compares all outputs as one vector against a reference function. The assertions are immediate and sit in a combinational process, so they judge each settled input combination without looking across cycles.

// File: rtl/lrAccessPkg.sv
package lrAccessPkg;

  // Control-to-datapath strobes: one outcome plus a match indication
  typedef struct packed {
    logic hit;
    logic undef;
    logic trap2;
    logic trap3;
    logic mem;
    logic direct;
  } lrStrobe_t;

  typedef enum logic [1:0] {
    LVL_USER  = 2'd0,
    LVL_KERN  = 2'd1,
    LVL_HYP   = 2'd2,
    LVL_MON   = 2'd3
  } lrLevel_e;

  localparam logic [1:0] ENC_OP0 = 2'b11;
  localparam logic [2:0] ENC_OP1 = 3'b100;
  localparam logic [3:0] ENC_CRN = 4'b1100;
  localparam logic [2:0] ENC_CRM_HI = 3'b110;
  localparam logic [5:0] SYNDROME_SYSREG = 6'h18;

endpackage

// File: rtl/lrAccessCtrl.sv
module lrAccessCtrl
  import lrAccessPkg::*;
#(
  parameter int NUM_LR = 4,
  parameter int IDX_W  = 4
) (
  input  logic [1:0]       op0,
  input  logic [2:0]       op1,
  input  logic [3:0]       crn,
  input  logic [3:0]       crm,
  input  logic [IDX_W-1:0] rawIdx,
  input  logic [1:0]       curEl,
  input  logic [2:0]       nvCtl,
  input  logic             sreEl2,
  input  logic             sreEl3,
  input  logic             hasIrqCtl,
  input  logic             hasEl2,
  input  logic             hasEl3,
  input  logic             has64,
  output lrStrobe_t        strobe
);

  localparam int IDX_SPAN = 1 << IDX_W;

  logic encHit;
  logic featOk;
  logic idxOk;
  lrLevel_e level;

  assign encHit = (op0 == ENC_OP0) && (op1 == ENC_OP1) &&
                  (crn == ENC_CRN) && (crm[3:1] == ENC_CRM_HI);
  assign featOk = hasIrqCtl && (hasEl2 || hasEl3) && has64;
  assign level  = lrLevel_e'(curEl);

  // Range compare is dropped when every encodable index is implemented
  generate
    if (NUM_LR >= IDX_SPAN) begin : g_fullRange
      assign idxOk = 1'b1;
    end else begin : g_partRange
      assign idxOk = ({1'b0, rawIdx} < (IDX_W+1)'(NUM_LR));
    end
  endgenerate

  always_comb begin
    strobe     = '0;
    strobe.hit = encHit;
    if (encHit) begin
      if (!featOk || !idxOk) begin
        strobe.undef = 1'b1;
      end else begin
        unique case (level)
          LVL_USER: strobe.undef = 1'b1;
          LVL_KERN: begin
            if (nvCtl[2] && nvCtl[0])  strobe.mem   = 1'b1;
            else if (nvCtl[0])         strobe.trap2 = 1'b1;
            else                       strobe.undef = 1'b1;
          end
          LVL_HYP: begin
            if (sreEl2) strobe.direct = 1'b1;
            else        strobe.trap2  = 1'b1;
          end
          LVL_MON: begin
            if (sreEl3) strobe.direct = 1'b1;
            else        strobe.trap3  = 1'b1;
          end
          default: strobe.undef = 1'b1;
        endcase
      end
    end
  end

endmodule

// File: rtl/lrAccessDp.sv
module lrAccessDp
  import lrAccessPkg::*;
#(
  parameter int                IDX_W    = 4,
  parameter int                ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] MEM_BASE = 12'h400,
  parameter int                STRIDE_LG = 3
) (
  input  logic [3:0]        crm,
  input  logic [2:0]        op2,
  input  lrStrobe_t         strobe,
  output logic [IDX_W-1:0]  rawIdx,
  output logic [IDX_W-1:0]  entryIdx,
  output logic [ADDR_W-1:0] memAddr,
  output logic [5:0]        trapClass
);

  logic [ADDR_W-1:0] offset;

  assign rawIdx    = IDX_W'({crm[0], op2});
  assign offset    = ADDR_W'(rawIdx) << STRIDE_LG;
  assign entryIdx  = (strobe.direct || strobe.mem) ? rawIdx : '0;
  assign memAddr   = strobe.mem ? (MEM_BASE + offset) : '0;
  assign trapClass = (strobe.trap2 || strobe.trap3) ? SYNDROME_SYSREG : '0;

endmodule

// File: rtl/lrAccessCheck.sv
module lrAccessCheck
  import lrAccessPkg::*;
#(
  parameter int          NUM_LR   = 4,
  parameter int          ADDR_W   = 12,
  parameter logic [11:0] MEM_BASE = 12'h400
) (
  input  logic [1:0]        op0,
  input  logic [2:0]        op1,
  input  logic [3:0]        crn,
  input  logic [3:0]        crm,
  input  logic [2:0]        op2,
  input  logic [1:0]        curEl,
  input  logic [2:0]        nvCtl,
  input  logic              sreEl2,
  input  logic              sreEl3,
  input  logic              hasIrqCtl,
  input  logic              hasEl2,
  input  logic              hasEl3,
  input  logic              has64,
  input  logic              isWrite,
  output logic              noMatch,
  output logic              isUndef,
  output logic              trapToEl2,
  output logic              trapToEl3,
  output logic              toMem,
  output logic              direct,
  output logic [3:0]        entryIdx,
  output logic [ADDR_W-1:0] memAddr,
  output logic [5:0]        trapClass,
  output logic              isWriteOut
);

  localparam int IDX_W = 4;

  lrStrobe_t        strobe;
  logic [IDX_W-1:0] rawIdx;

  lrAccessCtrl #(.NUM_LR(NUM_LR), .IDX_W(IDX_W)) u_ctrl (
    .op0(op0), .op1(op1), .crn(crn), .crm(crm), .rawIdx(rawIdx),
    .curEl(curEl), .nvCtl(nvCtl), .sreEl2(sreEl2), .sreEl3(sreEl3),
    .hasIrqCtl(hasIrqCtl), .hasEl2(hasEl2), .hasEl3(hasEl3), .has64(has64),
    .strobe(strobe)
  );

  lrAccessDp #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .MEM_BASE(ADDR_W'(MEM_BASE)),
               .STRIDE_LG(3)) u_dp (
    .crm(crm), .op2(op2), .strobe(strobe), .rawIdx(rawIdx),
    .entryIdx(entryIdx), .memAddr(memAddr), .trapClass(trapClass)
  );

  assign noMatch    = !strobe.hit;
  assign isUndef    = strobe.undef;
  assign trapToEl2  = strobe.trap2;
  assign trapToEl3  = strobe.trap3;
  assign toMem      = strobe.mem;
  assign direct     = strobe.direct;
  assign isWriteOut = isWrite;

endmodule

// File: rtl/lrAccessCheck_chk.sv
module lrAccessCheck_chk #(
  parameter int          NUM_LR   = 4,
  parameter int          ADDR_W   = 12,
  parameter logic [11:0] MEM_BASE = 12'h400
) (
  input logic [1:0]        curEl,
  input logic [2:0]        op2,
  input logic [3:0]        crm,
  input logic [2:0]        nvCtl,
  input logic              hasIrqCtl,
  input logic              hasEl2,
  input logic              hasEl3,
  input logic              has64,
  input logic              isWrite,
  input logic              noMatch,
  input logic              isUndef,
  input logic              trapToEl2,
  input logic              trapToEl3,
  input logic              toMem,
  input logic              direct,
  input logic [3:0]        entryIdx,
  input logic [ADDR_W-1:0] memAddr,
  input logic [5:0]        trapClass,
  input logic              isWriteOut
);

  logic [4:0] flags;
  assign flags = {isUndef, trapToEl2, trapToEl3, toMem, direct};

  always_comb begin
    if (noMatch) begin
      assert_quiet_R1: assert (flags == 5'd0);
    end else begin
      assert_onehot_R2: assert ($countones(flags) == 1);
    end
    if (!noMatch && !(hasIrqCtl && (hasEl2 || hasEl3) && has64)) begin
      assert_feature_R3: assert (isUndef);
    end
    if (!noMatch && ({crm[0], op2} >= 4'(NUM_LR))) begin
      assert_range_R4: assert (isUndef);
    end
    if (!noMatch && curEl == 2'd0) begin
      assert_user_R5: assert (isUndef);
    end
    if (toMem) begin
      assert_addr_R6: assert (curEl == 2'd1 && nvCtl[2] && nvCtl[0] &&
                              memAddr == ADDR_W'(MEM_BASE) + ADDR_W'({entryIdx, 3'b000}));
    end
    if (direct) begin
      assert_level_R8: assert (curEl[1]);
    end
    if (trapToEl3) begin
      assert_mon_R9: assert (curEl == 2'd3);
    end
    if (!toMem && !direct) begin
      assert_idx_R10: assert (entryIdx == 4'd0);
    end
    assert_dir_R11: assert (isWriteOut == isWrite);
    if (trapClass != 6'd0) begin
      assert_class_R10: assert (trapToEl2 || trapToEl3);
    end
  end

endmodule

bind lrAccessCheck lrAccessCheck_chk #(.NUM_LR(NUM_LR), .ADDR_W(ADDR_W), .MEM_BASE(MEM_BASE)) u_chk (
  .curEl(curEl), .op2(op2), .crm(crm), .nvCtl(nvCtl),
  .hasIrqCtl(hasIrqCtl), .hasEl2(hasEl2), .hasEl3(hasEl3), .has64(has64),
  .isWrite(isWrite), .noMatch(noMatch), .isUndef(isUndef),
  .trapToEl2(trapToEl2), .trapToEl3(trapToEl3), .toMem(toMem), .direct(direct),
  .entryIdx(entryIdx), .memAddr(memAddr), .trapClass(trapClass),
  .isWriteOut(isWriteOut)
);

// File: tb/lrAccessCheck_bench.sv
module lrAccessCheck_bench;

  localparam int NLR = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0] op0, curEl;
  logic [2:0] op1, op2, nvCtl;
  logic [3:0] crn, crm;
  logic sreEl2, sreEl3, hasIrqCtl, hasEl2, hasEl3, has64, isWrite;
  logic noMatch, isUndef, trapToEl2, trapToEl3, toMem, direct, isWriteOut;
  logic [3:0] entryIdx;
  logic [11:0] memAddr;
  logic [5:0] trapClass;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  lrAccessCheck #(.NUM_LR(NLR)) u_lrAccessCheck (.*);

  // Packed result: noMatch undef t2 t3 mem direct | idx | addr | class | dir
  typedef logic [34:0] res_t;

  function automatic res_t refModel(output string tag);
    logic hitRef, fOk;
    int idx;
    logic u, t2, t3, m, d;
    logic [11:0] a;
    logic [5:0] c;
    u = 0; t2 = 0; t3 = 0; m = 0; d = 0;
    idx = crm[0] * 8 + op2;
    hitRef = (op0 == 2'd3) && (op1 == 3'd4) && (crn == 4'd12) && (crm >= 4'd12) && (crm <= 4'd13);
    fOk = hasIrqCtl & (hasEl2 | hasEl3) & has64;
    tag = "R1";
    if (hitRef) begin
      if (!fOk) begin u = 1; tag = "R3"; end
      else if (idx >= NLR) begin u = 1; tag = "R4"; end
      else if (curEl == 0) begin u = 1; tag = "R5"; end
      else if (curEl == 1) begin
        if (nvCtl[0] && nvCtl[2]) begin m = 1; tag = "R6"; end
        else if (nvCtl[0]) begin t2 = 1; tag = "R7"; end
        else begin u = 1; tag = "R7"; end
      end else if (curEl == 2) begin
        tag = "R8";
        if (sreEl2) d = 1; else t2 = 1;
      end else begin
        tag = "R9";
        if (sreEl3) d = 1; else t3 = 1;
      end
    end
    a = m ? 12'(1024 + 8 * idx) : 12'd0;
    c = (t2 | t3) ? 6'd24 : 6'd0;
    return {!hitRef, u, t2, t3, m, d, ((m | d) ? 4'(idx) : 4'd0), a, c, isWrite};
  endfunction

  task automatic checkNow(input string note);
    res_t exp, got;
    string tag;
    exp = refModel(tag);
    got = {noMatch, isUndef, trapToEl2, trapToEl3, toMem, direct, entryIdx, memAddr, trapClass, isWriteOut};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s (also R2 R10 R11) %s: got %h expected %h", tag, note, got, exp);
    end
  endtask

  task automatic apply(input logic [1:0] o0, input logic [2:0] o1, input logic [3:0] cn,
                       input logic [3:0] cm, input logic [2:0] o2, input logic [1:0] el,
                       input logic [2:0] nv, input logic s2, input logic s3,
                       input logic [3:0] feat, input logic w, input string note);
    @(posedge clk); #1;
    op0 = o0; op1 = o1; crn = cn; crm = cm; op2 = o2; curEl = el; nvCtl = nv;
    sreEl2 = s2; sreEl3 = s3; {hasIrqCtl, hasEl2, hasEl3, has64} = feat; isWrite = w;
    @(negedge clk);
    checkNow(note);
  endtask

  initial begin
    fork
      begin : watchdog
        while (cycles < 150000) begin @(posedge clk); cycles++; end
        errors++; checks++;
        $display("FAIL watchdog expired: got hang expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none
  end

  initial begin
    void'($urandom(32'd20240611));
    {op0, op1, crn, crm, op2, curEl, nvCtl, sreEl2, sreEl3, hasIrqCtl, hasEl2, hasEl3, has64, isWrite} = '0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkNow("R1 idle state after reset");

    // Directed corners
    apply(2'd3, 3'd4, 4'd12, 4'd12, 3'd2, 2'd2, 3'd0, 1, 1, 4'hF, 0, "R8 direct idx2");
    apply(2'd3, 3'd4, 4'd12, 4'd12, 3'd2, 2'd2, 3'd0, 0, 1, 4'hF, 1, "R8 trap sre2=0");
    apply(2'd3, 3'd4, 4'd12, 4'd12, 3'd3, 2'd3, 3'd0, 1, 0, 4'hF, 0, "R9 trap sre3=0");
    apply(2'd3, 3'd4, 4'd12, 4'd12, 3'd3, 2'd3, 3'd0, 0, 1, 4'hF, 1, "R9 direct idx3");
    apply(2'd3, 3'd4, 4'd12, 4'd12, 3'd1, 2'd1, 3'b101, 1, 1, 4'hF, 0, "R6 redirect idx1 0x408");
    apply(2'd3, 3'd4, 4'd12, 4'd12, 3'd3, 2'd1, 3'b111, 1, 1, 4'hF, 1, "R6 redirect idx3 0x418");
    apply(2'd3, 3'd4, 4'd12, 4'd12, 3'd1, 2'd1, 3'b011, 1, 1, 4'hF, 0, "R7 trap pattern 011");
    apply(2'd3, 3'd4, 4'd12, 4'd12, 3'd1, 2'd1, 3'b110, 1, 1, 4'hF, 0, "R7 undef pattern 110");
    apply(2'd3, 3'd4, 4'd12, 4'd12, 3'd0, 2'd0, 3'b111, 1, 1, 4'hF, 1, "R5 EL0");
    apply(2'd3, 3'd4, 4'd12, 4'd12, 3'd4, 2'd2, 3'd0, 1, 1, 4'hF, 0, "R4 idx4 at limit");
    apply(2'd3, 3'd4, 4'd12, 4'd13, 3'd7, 2'd3, 3'd0, 1, 1, 4'hF, 0, "R4 idx15");
    apply(2'd3, 3'd4, 4'd12, 4'd12, 3'd0, 2'd2, 3'd0, 1, 1, 4'b1001, 0, "R3 no EL2 nor EL3");
    apply(2'd3, 3'd4, 4'd12, 4'd12, 3'd0, 2'd3, 3'd0, 1, 1, 4'b0111, 0, "R3 no controller");
    apply(2'd3, 3'd4, 4'd12, 4'd12, 3'd0, 2'd3, 3'd0, 1, 1, 4'b1110, 0, "R3 no 64-bit");
    apply(2'd3, 3'd4, 4'd12, 4'd12, 3'd0, 2'd3, 3'd0, 1, 1, 4'b1011, 0, "R3 EL3 only ok");
    apply(2'd3, 3'd4, 4'd12, 4'd14, 3'd0, 2'd2, 3'd0, 1, 1, 4'hF, 0, "R1 CRm 1110");
    apply(2'd2, 3'd4, 4'd12, 4'd12, 3'd0, 2'd2, 3'd0, 1, 1, 4'hF, 1, "R1 op0 differs");
    apply(2'd3, 3'd0, 4'd12, 4'd12, 3'd0, 2'd2, 3'd0, 1, 1, 4'hF, 0, "R1 op1 differs");
    apply(2'd3, 3'd4, 4'd11, 4'd12, 3'd0, 2'd2, 3'd0, 1, 1, 4'hF, 0, "R1 CRn differs");

    // Constrained random, biased toward the matching encoding
    for (int i = 0; i < 3000; i++) begin
      logic hit;
      hit = ($urandom_range(3) != 0);
      apply(hit ? 2'd3 : 2'($urandom), hit ? 3'd4 : 3'($urandom),
            hit ? 4'd12 : 4'($urandom), hit ? {3'b110, 1'($urandom)} : 4'($urandom),
            3'($urandom), 2'($urandom), 3'($urandom), 1'($urandom), 1'($urandom),
            ($urandom_range(4) == 0) ? 4'($urandom) : 4'hF, 1'($urandom), "random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule